// File: doc/BRIEF.md
# Rename Map Table with Branch Checkpoints

This block keeps the register-rename mapping of an out-of-order core. It has one entry per physical register, and each entry records the architectural register number that the physical register currently holds. Rename logic writes entries through an update port. Entries are read back through a combinational lookup port.

When a branch is taken, the core asks for a checkpoint. The whole table is copied, in one cycle, into a free checkpoint slot, and the slot number is returned as a tag. If the branch turns out to be mispredicted, a restore by that tag reloads every entry from the slot in one cycle. The restore also drops that slot and every checkpoint taken after it. If the branch was predicted correctly, a release frees its slot and leaves the live mapping as it is.

Every entry carries its own shadow copies, one per slot, beside the live value. Saves and restores are therefore local copies inside each entry and are never read out through the ports.

Top module: `rmap_table`

## Requirements
- R1: After reset, entry i of the live table reads i (modulo 2^AW), and no checkpoint slot is in use, so `stall` is low.
- R2: When `upd_en` is high and no restore is requested, entry `upd_preg` takes `upd_areg` at the clock edge. A lookup of an entry returns, combinationally, the value written at the most recent completed edge.
- R3: When `save_req` is high and `stall` and `restore_req` are both low, `save_ack` is high in the same cycle and `save_tag` gives the lowest-numbered free slot. That slot receives the live table as it stood before the edge, without any update made in the same cycle.
- R4: When `restore_req` is high, every live entry holds the contents of slot `restore_tag` after the next edge.
- R5: A restore discards an update, a save request and a release requested in the same cycle. No save is acknowledged in that cycle.
- R6: A restore frees slot `restore_tag` and every slot that was saved after it. Slots saved before it stay in use.
- R7: A release frees slot `release_tag` and leaves the live table unchanged.
- R8: `stall` is high exactly when all NCKPT slots are in use. While it is high a save request is not acknowledged and no slot is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Write one live entry |
| upd_preg | input | PW | Physical register to write |
| upd_areg | input | AW | Architectural number to store |
| lk_preg | input | PW | Physical register to look up |
| lk_areg | output | AW | Live architectural number of `lk_preg` |
| save_req | input | 1 | Take a checkpoint of the whole table |
| save_ack | output | 1 | Save accepted this cycle |
| save_tag | output | SW | Slot that the save fills |
| stall | output | 1 | All slots in use |
| restore_req | input | 1 | Reload the live table from a slot |
| restore_tag | input | SW | Slot to reload from |
| release_req | input | 1 | Free a slot without touching the table |
| release_tag | input | SW | Slot to free |

## Verification
The assertions assume that `restore_tag` and `release_tag` name a slot that is in use whenever their request is high. The bench model tracks which slots it has been granted and only restores or releases those. The sweep writes every entry with a computed pattern and fills all slots until `stall` rises. It then releases and restores in orders that leave both older and younger checkpoints standing, and compares the full table after each cycle.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
    // Per-entry operation issued by the slot controller
    typedef enum logic [1:0] {
        CELL_HOLD = 2'd0,
        CELL_SNAP = 2'd1,
        CELL_LOAD = 2'd2
    } cell_op_e;
endpackage

// File: rtl/rmap_entry.sv
module rmap_entry
    import rmap_pkg::*;
#(
    parameter int AW = 6,
    parameter int NCKPT = 4,
    parameter int SW = (NCKPT > 1) ? $clog2(NCKPT) : 1,
    parameter logic [AW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  cell_op_e      op,
    input  logic [SW-1:0] slot,
    output logic [AW-1:0] live
);
    typedef struct packed {
        logic [AW-1:0]             live;
        logic [NCKPT-1:0][AW-1:0]  shadow;
    } entry_t;

    entry_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            CELL_LOAD: st_d.live = st_q.shadow[slot];
            CELL_SNAP: begin
                st_d.shadow[slot] = st_q.live;
                if (wr_en) st_d.live = wr_data;
            end
            default: if (wr_en) st_d.live = wr_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.live   <= RST_VAL;
            st_q.shadow <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live = st_q.live;

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == CELL_LOAD |=> live == $past(st_q.shadow[slot]));
    // R3
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == CELL_SNAP |=> st_q.shadow[$past(slot)] == $past(live));
    // R7
    hold_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op != CELL_LOAD && !wr_en) |=> $stable(live));
endmodule

// File: rtl/rmap_ckpt_ctl.sv
module rmap_ckpt_ctl
    import rmap_pkg::*;
#(
    parameter int NCKPT = 4,
    parameter int SW = (NCKPT > 1) ? $clog2(NCKPT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          restore_req,
    input  logic [SW-1:0] restore_tag,
    input  logic          release_req,
    input  logic [SW-1:0] release_tag,
    output logic          save_ack,
    output logic [SW-1:0] save_tag,
    output logic          stall,
    output cell_op_e      cell_op,
    output logic [SW-1:0] cell_slot
);
    // older[i][j] set: slot i was saved before slot j
    typedef struct packed {
        logic [NCKPT-1:0]             valid;
        logic [NCKPT-1:0][NCKPT-1:0]  older;
    } ctl_t;

    ctl_t st_d, st_q;
    logic [SW-1:0] free_idx;
    logic          rel_fire;

    always_comb begin
        free_idx = '0;
        for (int k = NCKPT - 1; k >= 0; k--) begin
            if (!st_q.valid[k]) free_idx = SW'(k);
        end
    end

    assign stall    = &st_q.valid;
    assign save_ack = save_req && !stall && !restore_req;
    assign save_tag = free_idx;
    assign rel_fire = release_req && !restore_req;

    always_comb begin
        st_d = st_q;
        if (restore_req) begin
            for (int j = 0; j < NCKPT; j++) begin
                if (st_q.older[restore_tag][j]) st_d.valid[j] = 1'b0;
            end
            st_d.valid[restore_tag] = 1'b0;
        end else begin
            if (rel_fire) st_d.valid[release_tag] = 1'b0;
            if (save_ack) begin
                for (int j = 0; j < NCKPT; j++) begin
                    st_d.older[j][free_idx] = st_q.valid[j];
                    st_d.older[free_idx][j] = 1'b0;
                end
                st_d.valid[free_idx] = 1'b1;
            end
        end
    end

    always_comb begin
        cell_op   = CELL_HOLD;
        cell_slot = free_idx;
        if (restore_req) begin
            cell_op   = CELL_LOAD;
            cell_slot = restore_tag;
        end else if (save_ack) begin
            cell_op   = CELL_SNAP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.older <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    save_takes_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_ack |=> st_q.valid[$past(save_tag)]);
    // R6
    restore_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |=> !st_q.valid[$past(restore_tag)]);
    // R7
    release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && !restore_req) |=> !st_q.valid[$past(release_tag)]);
    // R6
    restore_tag_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |-> st_q.valid[restore_tag]);
    // R7
    release_tag_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |-> st_q.valid[release_tag]);
    // R8
    stall_no_grab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !release_req && !restore_req) |=> stall);
endmodule

// File: rtl/rmap_table.sv
module rmap_table
    import rmap_pkg::*;
#(
    parameter int NPHYS = 16,
    parameter int AW = 6,
    parameter int NCKPT = 4,
    localparam int PW = (NPHYS > 1) ? $clog2(NPHYS) : 1,
    localparam int SW = (NCKPT > 1) ? $clog2(NCKPT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic [PW-1:0] upd_preg,
    input  logic [AW-1:0] upd_areg,
    input  logic [PW-1:0] lk_preg,
    output logic [AW-1:0] lk_areg,
    input  logic          save_req,
    output logic          save_ack,
    output logic [SW-1:0] save_tag,
    output logic          stall,
    input  logic          restore_req,
    input  logic [SW-1:0] restore_tag,
    input  logic          release_req,
    input  logic [SW-1:0] release_tag
);
    cell_op_e      cell_op;
    logic [SW-1:0] cell_slot;
    logic [AW-1:0] live_arr [NPHYS];

    rmap_ckpt_ctl #(.NCKPT(NCKPT), .SW(SW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .save_req   (save_req),
        .restore_req(restore_req),
        .restore_tag(restore_tag),
        .release_req(release_req),
        .release_tag(release_tag),
        .save_ack   (save_ack),
        .save_tag   (save_tag),
        .stall      (stall),
        .cell_op    (cell_op),
        .cell_slot  (cell_slot)
    );

    for (genvar i = 0; i < NPHYS; i++) begin : g_entry
        logic wr_hit;
        assign wr_hit = upd_en && (upd_preg == PW'(i));
        rmap_entry #(
            .AW(AW), .NCKPT(NCKPT), .SW(SW), .RST_VAL(AW'(i))
        ) u_entry (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_hit),
            .wr_data(upd_areg),
            .op     (cell_op),
            .slot   (cell_slot),
            .live   (live_arr[i])
        );
    end

    assign lk_areg = live_arr[lk_preg];

    // R5
    restore_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |-> !save_ack);
endmodule

// File: tb/rmap_table_tb.sv
module rmap_table_tb;
    localparam int NPHYS = 16;
    localparam int AW = 6;
    localparam int NCKPT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_en = 0, save_req = 0, restore_req = 0, release_req = 0;
    logic [3:0] upd_preg = '0, lk_preg = '0;
    logic [5:0] upd_areg = '0, lk_areg;
    logic [1:0] restore_tag = '0, release_tag = '0, save_tag;
    logic save_ack, stall;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    int m_map [NPHYS];
    int m_shd [NCKPT][NPHYS];
    bit m_val [NCKPT];
    int m_seq [NCKPT];
    int seq_ctr = 0;

    always #5 clk = ~clk;

    rmap_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .upd_en(upd_en), .upd_preg(upd_preg), .upd_areg(upd_areg),
        .lk_preg(lk_preg), .lk_areg(lk_areg),
        .save_req(save_req), .save_ack(save_ack), .save_tag(save_tag), .stall(stall),
        .restore_req(restore_req), .restore_tag(restore_tag),
        .release_req(release_req), .release_tag(release_tag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_table(input string req);
        for (int i = 0; i < NPHYS; i++) begin
            lk_preg = 4'(i);
            #1;
            chk(req, $sformatf("entry %0d", i), int'(lk_areg), m_map[i]);
        end
    endtask

    function automatic bit m_full();
        for (int s = 0; s < NCKPT; s++) if (!m_val[s]) return 0;
        return 1;
    endfunction

    function automatic int m_free();
        for (int s = 0; s < NCKPT; s++) if (!m_val[s]) return s;
        return 0;
    endfunction

    // called at a negedge; drives one cycle, updates the model, checks at next negedge
    task automatic cyc(input string req, input bit ue, input int up, input int ua,
                       input bit sv, input bit rs, input int rt, input bit rl, input int lt);
        bit eack;
        int etag;
        upd_en = ue; upd_preg = 4'(up); upd_areg = 6'(ua);
        save_req = sv; restore_req = rs; restore_tag = 2'(rt);
        release_req = rl; release_tag = 2'(lt);
        #1;
        eack = sv && !m_full() && !rs;
        etag = m_free();
        chk(req, "stall", int'(stall), int'(m_full()));
        chk(req, "save_ack", int'(save_ack), int'(eack));
        if (eack) chk(req, "save_tag", int'(save_tag), etag);
        if (rs) begin
            int tseq = m_seq[rt];
            for (int e = 0; e < NPHYS; e++) m_map[e] = m_shd[rt][e];
            for (int s = 0; s < NCKPT; s++) if (m_val[s] && m_seq[s] > tseq) m_val[s] = 0;
            m_val[rt] = 0;
        end else begin
            if (eack) begin
                for (int e = 0; e < NPHYS; e++) m_shd[etag][e] = m_map[e];
                m_val[etag] = 1;
                m_seq[etag] = seq_ctr++;
            end
            if (rl) m_val[lt] = 0;
            if (ue) m_map[up] = ua;
        end
        @(posedge clk);
        @(negedge clk);
        upd_en = 0; save_req = 0; restore_req = 0; release_req = 0;
        check_table(req);
        #1;
        chk(req, "stall after", int'(stall), int'(m_full()));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NPHYS; i++) m_map[i] = i % 64;
        for (int s = 0; s < NCKPT; s++) begin m_val[s] = 0; m_seq[s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_table("R1");
        chk("R1", "stall at reset", int'(stall), 0);

        // R2 sweep writes to every entry
        for (int i = 0; i < NPHYS; i++) cyc("R2", 1, i, (i * 5 + 3) % 64, 0, 0, 0, 0, 0);

        // R3 save with same-cycle update: snapshot holds old value
        cyc("R3", 1, 2, 40, 1, 0, 0, 0, 0);
        for (int s = 1; s < NCKPT; s++) begin
            for (int i = 0; i < NPHYS; i += 3) cyc("R2", 1, i, (i * 7 + s * 11) % 64, 0, 0, 0, 0, 0);
            cyc("R3", 0, 0, 0, 1, 0, 0, 0, 0);
        end
        // R8 full: save refused
        cyc("R8", 1, 5, 9, 1, 0, 0, 0, 0);
        chk("R8", "stall full", int'(stall), 1);

        // R7 release slot 1, table unchanged; next save reuses slot 1 (youngest)
        cyc("R7", 0, 0, 0, 0, 0, 0, 1, 1);
        cyc("R2", 1, 7, 63, 0, 0, 0, 0, 0);
        cyc("R3", 0, 0, 0, 1, 0, 0, 0, 0);

        // R4 R5 restore slot 2 with update, save and release requested together
        cyc("R5", 1, 2, 17, 1, 1, 2, 1, 0);
        // R6 slot 0 older stays, slots 1,2,3 freed; fill again
        for (int k = 0; k < 3; k++) begin
            cyc("R6", 1, k + 8, k + 50, 0, 0, 0, 0, 0);
            cyc("R6", 0, 0, 0, 1, 0, 0, 0, 0);
        end
        cyc("R8", 0, 0, 0, 1, 0, 0, 0, 0);
        // R6 restore youngest (slot 3): only it freed
        cyc("R6", 0, 0, 0, 0, 1, 3, 0, 0);
        cyc("R6", 0, 0, 0, 1, 0, 0, 0, 0);
        // R4 restore oldest slot 0: everything freed
        cyc("R4", 1, 1, 33, 0, 1, 0, 0, 0);
        for (int s = 0; s < NCKPT; s++) begin
            cyc("R2", 1, s, 60 - s, 0, 0, 0, 0, 0);
            cyc("R3", 0, 0, 0, 1, 0, 0, 0, 0);
        end
        // R7 release middle slot, then restore slot 1: slots 3 gone, 0 stays
        cyc("R7", 1, 4, 4, 0, 0, 0, 1, 2);
        cyc("R6", 0, 0, 0, 0, 1, 1, 0, 0);
        cyc("R4", 0, 0, 0, 0, 1, 0, 0, 0);
        cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule